// File: doc/BRIEF.md
# Flow Table Insertion Controller

This block owns a flow table held in synchronous on-chip RAM. Each slot holds one 32-bit control word and a parameterised number of 32-bit data words. A client that has already hashed a flow submits a commit: a hash index, a new control word, the data words and a 15-bit timestamp. The controller merges the timestamp into the control word, probes at most two neighbouring slots for one it may overwrite, writes the data first and the control word last, and then reports the slot it chose or that no space was found. After every successful commit it pulses a cache-clear strobe toward the lookup engine.

Two maintenance sequences share the write path. Init zeroes every slot and, when requested, marks a fixed set of offsets in every 128-slot group as static so they are never handed out. Stop invalidates every control word and then waits, with a bounded timeout, for the forwarding engine to report that it is idle. Both walk one slot per clock and end with a done pulse. A read-only lookup port lets the forwarding side fetch any slot's contents.

Top module: `flow_insert_ctrl`

## Requirements
- R1: A slot may be overwritten only when bit 31 of its control word (static) is 0 and bits [29:28] (state: 0 invalid, 1 unbind, 2 bind, 3 fin) are not 2; unbind, fin and invalid slots are overwritten.
- R2: The stored control word equals the submitted control word with bits [14:0] replaced by `cmt_ts`; bits [31:15] are kept.
- R3: A commit probes slot `cmt_hash` first and, only if that slot is unusable, slot `cmt_hash+1`, where the slot after the last one is slot 0.
- R4: When both probed slots are unusable, `cmt_done` pulses with `cmt_ok` low, no slot is modified and `cache_clr` stays low.
- R5: The data words of the chosen slot are written in the clock cycle before its control word, at the same index.
- R6: A successful commit raises `cmt_done` and `cmt_ok` for one cycle with `cmt_slot` giving the chosen index, and `cache_clr` is high in exactly that cycle and low in the next.
- R7: Init writes control word 0 and all-zero data to every slot, one per cycle, and then pulses `seq_done` for one cycle.
- R8: When `init_rsv` is 1 at the start of init, slots whose index modulo 128 is 12, 25, 38, 51, 76, 89 or 102 receive control word 0x8000_0000 (static, invalid); when 0 they receive 0.
- R9: Stop writes control word 0 to every slot, then pulses `seq_done` as soon as `eng_busy` is low with `stop_tmo` 0, or after `TMO_CYC` busy cycles with `stop_tmo` 1; `stop_tmo` holds until the next stop.
- R10: A commit request made while a commit, init or stop is in progress is refused: `cmt_rej` pulses on the next cycle and the table is not changed.
- R11: In the idle state `init_req` wins over `stop_req`, which wins over `cmt_req`; a commit request in the same cycle as an init or stop request is refused.
- R12: The lookup port returns the control word and data of slot `lk_idx` one cycle after `lk_idx` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmt_req | input | 1 | Commit request, one-cycle pulse |
| cmt_hash | input | IDX_W | Home slot index of the flow |
| cmt_ctrl | input | 32 | New control word |
| cmt_ts | input | 15 | Timestamp merged into control bits [14:0] |
| cmt_data | input | DATA_WORDS*32 | Data words, word 0 in the low bits |
| cmt_done | output | 1 | Accepted commit finished |
| cmt_ok | output | 1 | With `cmt_done`: 1 written, 0 no space |
| cmt_slot | output | IDX_W | Slot written by the commit |
| cmt_rej | output | 1 | Commit request refused |
| cache_clr | output | 1 | Lookup cache clear strobe |
| init_req | input | 1 | Start init sequence |
| init_rsv | input | 1 | Reserve static slots during init |
| stop_req | input | 1 | Start stop sequence |
| eng_busy | input | 1 | Forwarding engine still busy |
| seq_done | output | 1 | Init or stop finished |
| stop_tmo | output | 1 | Last stop ended by timeout |
| lk_idx | input | IDX_W | Lookup slot index |
| lk_ctrl | output | 32 | Control word of looked-up slot |
| lk_data | output | DATA_WORDS*32 | Data words of looked-up slot |

## Verification
The bench fills the home slot and its neighbour with bound entries and commits a third time to the same hash: a design that probed further or ignored state would overwrite a live flow instead of reporting no space. It commits at the last index twice to catch a probe that runs off the table rather than wrapping to slot 0, and at a reserved offset to catch a static slot being handed out, while unbind and fin slots must still be reused. Commits sent during init, during stop and in the same cycle as an init request must be refused and leave the table untouched, and the stop is run both with the engine idle and held busy so that a missing or stuck timeout is exposed.

// File: rtl/flow_ins_pkg.sv
package flow_ins_pkg;

  localparam int CTRL_W = 32;
  localparam int TS_W   = 15;
  localparam logic [CTRL_W-1:0] TS_MASK     = 32'h0000_7FFF;
  localparam logic [CTRL_W-1:0] CTRL_STATIC = 32'h8000_0000;

  typedef enum logic [1:0] {
    FS_INVALID = 2'd0,
    FS_UNBIND  = 2'd1,
    FS_BIND    = 2'd2,
    FS_FIN     = 2'd3
  } flow_state_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_CHK0, S_RD1, S_CHK1,
    S_WDATA, S_WCTRL, S_INIT, S_STOP, S_WAIT
  } seq_st_e;

  function automatic logic slot_usable(input logic [CTRL_W-1:0] c);
    return !c[31] && (flow_state_e'(c[29:28]) != FS_BIND);
  endfunction

  function automatic logic rsv_offset(input logic [6:0] off);
    case (off)
      7'd12, 7'd25, 7'd38, 7'd51, 7'd76, 7'd89, 7'd102: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/flow_tbl_ram.sv
module flow_tbl_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  parameter int NRD   = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [WIDTH-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      rdata[p] <= mem[raddr[p]];
    end
  end

endmodule

// File: rtl/flow_ins_fsm.sv
module flow_ins_fsm
  import flow_ins_pkg::*;
#(
  parameter int ENTRIES    = 256,
  parameter int DATA_WORDS = 19,
  parameter int TMO_CYC    = 64,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int DATA_W    = DATA_WORDS * 32,
  localparam int TMO_W     = $clog2(TMO_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmt_req,
  input  logic [IDX_W-1:0]  cmt_hash,
  input  logic [31:0]       cmt_ctrl,
  input  logic [TS_W-1:0]   cmt_ts,
  input  logic [DATA_W-1:0] cmt_data,
  input  logic              init_req,
  input  logic              init_rsv,
  input  logic              stop_req,
  input  logic              eng_busy,
  input  logic [31:0]       rd_ctrl,
  output logic [IDX_W-1:0]  idx,
  output logic              ctrl_we,
  output logic [31:0]       ctrl_wd,
  output logic              data_we,
  output logic [DATA_W-1:0] data_wd,
  output seq_st_e           st,
  output logic              cmt_done,
  output logic              cmt_ok,
  output logic [IDX_W-1:0]  cmt_slot,
  output logic              cmt_rej,
  output logic              cache_clr,
  output logic              seq_done,
  output logic              stop_tmo
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [31:0]       ctrl_q;
  logic [DATA_W-1:0] data_q;
  logic              rsv_q;
  logic [TMO_W-1:0]  tmo_cnt;
  logic              accept;

  assign accept = (st == S_IDLE) && !init_req && !stop_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      idx       <= '0;
      ctrl_q    <= '0;
      data_q    <= '0;
      rsv_q     <= 1'b0;
      tmo_cnt   <= '0;
      cmt_done  <= 1'b0;
      cmt_ok    <= 1'b0;
      cmt_slot  <= '0;
      cmt_rej   <= 1'b0;
      cache_clr <= 1'b0;
      seq_done  <= 1'b0;
      stop_tmo  <= 1'b0;
    end else begin
      cmt_done  <= 1'b0;
      cmt_ok    <= 1'b0;
      cache_clr <= 1'b0;
      seq_done  <= 1'b0;
      cmt_rej   <= cmt_req && !accept;
      case (st)
        S_IDLE: begin
          if (init_req) begin
            idx   <= '0;
            rsv_q <= init_rsv;
            st    <= S_INIT;
          end else if (stop_req) begin
            idx      <= '0;
            stop_tmo <= 1'b0;
            st       <= S_STOP;
          end else if (cmt_req) begin
            idx    <= cmt_hash;
            ctrl_q <= (cmt_ctrl & ~TS_MASK) | {{(32-TS_W){1'b0}}, cmt_ts};
            data_q <= cmt_data;
            st     <= S_RD0;
          end
        end
        S_RD0: st <= S_CHK0;
        S_CHK0: begin
          if (slot_usable(rd_ctrl)) st <= S_WDATA;
          else begin
            idx <= idx + IDX_W'(1);
            st  <= S_RD1;
          end
        end
        S_RD1: st <= S_CHK1;
        S_CHK1: begin
          if (slot_usable(rd_ctrl)) st <= S_WDATA;
          else begin
            cmt_done <= 1'b1;
            st       <= S_IDLE;
          end
        end
        S_WDATA: st <= S_WCTRL;
        S_WCTRL: begin
          cmt_done  <= 1'b1;
          cmt_ok    <= 1'b1;
          cmt_slot  <= idx;
          cache_clr <= 1'b1;
          st        <= S_IDLE;
        end
        S_INIT: begin
          idx <= idx + IDX_W'(1);
          if (idx == LAST) begin
            seq_done <= 1'b1;
            st       <= S_IDLE;
          end
        end
        S_STOP: begin
          idx <= idx + IDX_W'(1);
          if (idx == LAST) begin
            tmo_cnt <= '0;
            st      <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (!eng_busy) begin
            seq_done <= 1'b1;
            st       <= S_IDLE;
          end else if (tmo_cnt == TMO_W'(TMO_CYC - 1)) begin
            seq_done <= 1'b1;
            stop_tmo <= 1'b1;
            st       <= S_IDLE;
          end else begin
            tmo_cnt <= tmo_cnt + TMO_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl_we = (st == S_WCTRL) || (st == S_INIT) || (st == S_STOP);
    if (st == S_WCTRL)                             ctrl_wd = ctrl_q;
    else if (st == S_INIT && rsv_q && rsv_offset(idx[6:0])) ctrl_wd = CTRL_STATIC;
    else                                           ctrl_wd = '0;
    data_we = (st == S_WDATA) || (st == S_INIT);
    data_wd = (st == S_WDATA) ? data_q : '0;
  end

endmodule

// File: rtl/flow_insert_ctrl.sv
module flow_insert_ctrl
  import flow_ins_pkg::*;
#(
  parameter int ENTRIES    = 256,
  parameter int DATA_WORDS = 19,
  parameter int TMO_CYC    = 64,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int DATA_W    = DATA_WORDS * 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmt_req,
  input  logic [IDX_W-1:0]  cmt_hash,
  input  logic [31:0]       cmt_ctrl,
  input  logic [TS_W-1:0]   cmt_ts,
  input  logic [DATA_W-1:0] cmt_data,
  output logic              cmt_done,
  output logic              cmt_ok,
  output logic [IDX_W-1:0]  cmt_slot,
  output logic              cmt_rej,
  output logic              cache_clr,
  input  logic              init_req,
  input  logic              init_rsv,
  input  logic              stop_req,
  input  logic              eng_busy,
  output logic              seq_done,
  output logic              stop_tmo,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [31:0]       lk_ctrl,
  output logic [DATA_W-1:0] lk_data
);

  logic [IDX_W-1:0]    wr_idx;
  logic                ctrl_we, data_we;
  logic [31:0]         ctrl_wd;
  logic [DATA_W-1:0]   data_wd;
  logic [1:0][31:0]    ctrl_rd;
  logic [0:0][DATA_W-1:0] data_rd;
  seq_st_e             fsm_st;

  flow_ins_fsm #(
    .ENTRIES(ENTRIES), .DATA_WORDS(DATA_WORDS), .TMO_CYC(TMO_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .cmt_req(cmt_req), .cmt_hash(cmt_hash), .cmt_ctrl(cmt_ctrl),
    .cmt_ts(cmt_ts), .cmt_data(cmt_data),
    .init_req(init_req), .init_rsv(init_rsv), .stop_req(stop_req),
    .eng_busy(eng_busy), .rd_ctrl(ctrl_rd[0]),
    .idx(wr_idx), .ctrl_we(ctrl_we), .ctrl_wd(ctrl_wd),
    .data_we(data_we), .data_wd(data_wd), .st(fsm_st),
    .cmt_done(cmt_done), .cmt_ok(cmt_ok), .cmt_slot(cmt_slot),
    .cmt_rej(cmt_rej), .cache_clr(cache_clr),
    .seq_done(seq_done), .stop_tmo(stop_tmo)
  );

  flow_tbl_ram #(.DEPTH(ENTRIES), .WIDTH(32), .NRD(2)) u_ctrl_ram (
    .clk(clk), .we(ctrl_we), .waddr(wr_idx), .wdata(ctrl_wd),
    .raddr({lk_idx, wr_idx}), .rdata(ctrl_rd)
  );

  flow_tbl_ram #(.DEPTH(ENTRIES), .WIDTH(DATA_W), .NRD(1)) u_data_ram (
    .clk(clk), .we(data_we), .waddr(wr_idx), .wdata(data_wd),
    .raddr(lk_idx), .rdata(data_rd)
  );

  assign lk_ctrl = ctrl_rd[1];
  assign lk_data = data_rd[0];

endmodule

// File: rtl/flow_insert_ctrl_chk.sv
module flow_insert_ctrl_chk
  import flow_ins_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmt_req,
  input logic             cmt_done,
  input logic             cmt_ok,
  input logic             cmt_rej,
  input logic             cache_clr,
  input logic             seq_done,
  input seq_st_e          fsm_st,
  input logic             data_we,
  input logic [IDX_W-1:0] wr_idx
);

  a_r6_clr_with_ok: assert property (@(posedge clk) disable iff (rst)
    cmt_done && cmt_ok |-> cache_clr);

  a_r6_clr_single: assert property (@(posedge clk) disable iff (rst)
    cache_clr |=> !cache_clr);

  a_r4_full_no_clr: assert property (@(posedge clk) disable iff (rst)
    cmt_done && !cmt_ok |-> !cache_clr);

  a_r5_data_first: assert property (@(posedge clk) disable iff (rst)
    fsm_st == S_WCTRL |-> $past(data_we) && ($past(wr_idx) == wr_idx));

  a_r10_refuse_busy: assert property (@(posedge clk) disable iff (rst)
    cmt_req && fsm_st != S_IDLE |=> cmt_rej);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> !seq_done);

endmodule

bind flow_insert_ctrl flow_insert_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .cmt_req(cmt_req), .cmt_done(cmt_done),
  .cmt_ok(cmt_ok), .cmt_rej(cmt_rej), .cache_clr(cache_clr),
  .seq_done(seq_done), .fsm_st(fsm_st), .data_we(data_we), .wr_idx(wr_idx)
);

// File: tb/flow_insert_ctrl_tb_top.sv
module flow_insert_ctrl_tb_top;

  localparam int ENTRIES = 256;
  localparam int DW      = 19;
  localparam int IW      = 8;
  localparam int DBW     = DW * 32;
  localparam logic [31:0] BIND_C = 32'h2400_7FFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmt_req = 0, init_req = 0, init_rsv = 0, stop_req = 0, eng_busy = 0;
  logic [IW-1:0] cmt_hash = '0, lk_idx = '0;
  logic [31:0] cmt_ctrl = '0;
  logic [14:0] cmt_ts = '0;
  logic [DBW-1:0] cmt_data = '0;
  logic cmt_done, cmt_ok, cmt_rej, cache_clr, seq_done, stop_tmo;
  logic [IW-1:0] cmt_slot;
  logic [31:0] lk_ctrl;
  logic [DBW-1:0] lk_data;

  int n_chk = 0, n_fail = 0;

  typedef struct { bit rej; bit ok; logic [IW-1:0] slot; string req; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  flow_insert_ctrl dut_i (
    .clk(clk), .rst(rst), .cmt_req(cmt_req), .cmt_hash(cmt_hash),
    .cmt_ctrl(cmt_ctrl), .cmt_ts(cmt_ts), .cmt_data(cmt_data),
    .cmt_done(cmt_done), .cmt_ok(cmt_ok), .cmt_slot(cmt_slot),
    .cmt_rej(cmt_rej), .cache_clr(cache_clr), .init_req(init_req),
    .init_rsv(init_rsv), .stop_req(stop_req), .eng_busy(eng_busy),
    .seq_done(seq_done), .stop_tmo(stop_tmo), .lk_idx(lk_idx),
    .lk_ctrl(lk_ctrl), .lk_data(lk_data)
  );

  task automatic chk(input bit cond, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [DBW-1:0] mkdata(input int seed);
    logic [DBW-1:0] v;
    for (int i = 0; i < DW; i++) v[i*32 +: 32] = {seed[15:0], 16'(i)} ^ 32'hA5A5_0000;
    return v;
  endfunction

  // monitor: pops the scoreboard on every result
  always @(negedge clk) begin
    if (!rst && (cmt_done || cmt_rej)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected result", {30'd0, cmt_done, cmt_rej}, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.rej) begin
          chk(cmt_rej && !cmt_done, e.req, {31'd0, cmt_rej}, 32'd1);
        end else begin
          chk(cmt_done && cmt_ok == e.ok, e.req, {31'd0, cmt_ok}, {31'd0, e.ok});
          if (e.ok) chk(cmt_slot == e.slot, e.req, 32'(cmt_slot), 32'(e.slot));
          chk(cache_clr == e.ok, "R6 cache clear with result", {31'd0, cache_clr},
              {31'd0, e.ok});
        end
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic commit(input logic [IW-1:0] h, input logic [31:0] c,
                        input logic [14:0] ts, input int seed, input bit ok,
                        input logic [IW-1:0] slot, input string req);
    exp_t e;
    e.rej = 0; e.ok = ok; e.slot = slot; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    cmt_req = 1; cmt_hash = h; cmt_ctrl = c; cmt_ts = ts; cmt_data = mkdata(seed);
    @(negedge clk);
    cmt_req = 0;
    drain();
  endtask

  task automatic refuse_pulse(input string req);
    exp_t e;
    e.rej = 1; e.ok = 0; e.slot = '0; e.req = req;
    exp_q.push_back(e);
    cmt_req = 1; cmt_hash = 8'd200; cmt_ctrl = BIND_C; cmt_ts = 15'd3;
    @(negedge clk);
    cmt_req = 0;
  endtask

  task automatic wait_done();
    while (!seq_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic look(input logic [IW-1:0] i, input logic [31:0] exp, input string req);
    @(negedge clk);
    lk_idx = i;
    @(negedge clk);
    chk(lk_ctrl == exp, req, lk_ctrl, exp);
  endtask

  task automatic look_data(input logic [IW-1:0] i, input logic [DBW-1:0] exp,
                           input string req);
    @(negedge clk);
    lk_idx = i;
    @(negedge clk);
    chk(lk_data == exp, req, lk_data[31:0], exp[31:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmt_done && !cmt_rej && !cache_clr && !seq_done, "R6 reset outputs quiet",
        {28'd0, cmt_done, cmt_rej, cache_clr, seq_done}, 32'd0);
    rst = 0;
    @(negedge clk);

    // R11: init with a commit in the same cycle; commit refused
    init_req = 1; init_rsv = 1;
    begin
      exp_t e; e.rej = 1; e.ok = 0; e.slot = '0; e.req = "R11 commit beside init refused";
      exp_q.push_back(e);
    end
    cmt_req = 1; cmt_hash = 8'd200; cmt_ctrl = BIND_C;
    @(negedge clk);
    init_req = 0; cmt_req = 0;
    repeat (4) @(negedge clk);
    refuse_pulse("R10 commit during init refused");
    wait_done();
    chk(exp_q.size() == 0, "R10 refusals seen", exp_q.size(), 0);
    look(8'd12,  32'h8000_0000, "R8 reserved offset 12");
    look(8'd140, 32'h8000_0000, "R8 reserved offset 12 in group 1");
    look(8'd230, 32'h8000_0000, "R8 reserved offset 102 in group 1");
    look(8'd64,  32'h0, "R8 offset 64 not reserved");
    look(8'd13,  32'h0, "R7 ordinary slot zeroed");
    look(8'd200, 32'h0, "R10 refused commit wrote nothing");

    commit(8'd5, BIND_C, 15'h1234, 1, 1, 8'd5, "R3 home slot free");
    look(8'd5, 32'h2400_1234, "R2 timestamp merged");
    look_data(8'd5, mkdata(1), "R12 data readback");
    commit(8'd5, BIND_C, 15'h0001, 2, 1, 8'd6, "R3 bound home goes to next");
    look(8'd6, 32'h2400_0001, "R2 second slot control");
    commit(8'd5, BIND_C, 15'h0002, 3, 0, 8'd0, "R4 both bound no space");
    look(8'd5, 32'h2400_1234, "R4 home untouched");
    look(8'd6, 32'h2400_0001, "R4 neighbour untouched");
    look_data(8'd6, mkdata(2), "R4 neighbour data untouched");

    commit(8'd12, 32'h1000_0000, 15'd7, 4, 1, 8'd13, "R1 static slot skipped");
    look(8'd13, 32'h1000_0007, "R1 unbind written");
    commit(8'd13, BIND_C, 15'd5, 5, 1, 8'd13, "R1 unbind slot reused");
    look(8'd13, 32'h2400_0005, "R1 unbind overwritten");
    commit(8'd40, 32'h3000_0000, 15'd0, 6, 1, 8'd40, "R1 invalid slot used");
    commit(8'd40, BIND_C, 15'd1, 7, 1, 8'd40, "R1 fin slot reused");

    commit(8'd255, BIND_C, 15'd9, 8, 1, 8'd255, "R3 last slot");
    commit(8'd255, BIND_C, 15'd10, 9, 1, 8'd0, "R3 wrap to slot 0");
    look_data(8'd0, mkdata(9), "R5 wrapped slot data");
    look(8'd0, 32'h2400_000A, "R3 wrapped slot control");

    // R9: stop, engine idle
    @(negedge clk);
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
    @(negedge clk);
    refuse_pulse("R10 commit during stop refused");
    wait_done();
    chk(stop_tmo == 0, "R9 stop without timeout", {31'd0, stop_tmo}, 32'd0);
    look(8'd5,  32'h0, "R9 bound slot invalidated");
    look(8'd12, 32'h0, "R9 static slot cleared");

    // R9: stop, engine stays busy
    eng_busy = 1;
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
    wait_done();
    chk(stop_tmo == 1, "R9 stop timeout", {31'd0, stop_tmo}, 32'd1);
    eng_busy = 0;

    // R7/R8: init without reserve
    init_req = 1; init_rsv = 0;
    @(negedge clk);
    init_req = 0;
    wait_done();
    look(8'd12, 32'h0, "R8 no reserve when disabled");
    look_data(8'd5, '0, "R7 data zeroed");
    commit(8'd11, BIND_C, 15'd1, 10, 1, 8'd11, "R3 plain commit");
    commit(8'd11, BIND_C, 15'd2, 11, 1, 8'd12, "R8 offset 12 usable unreserved");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule